// File: doc/BRIEF.md
# Multi-Lane Link Test Pattern Generator

This block produces one 32-bit symbol per clock on each of four lanes of a serial display link. A global link mode decides whether the lanes carry normal payload, one of two training sequences, or test patterns. In test-pattern mode every lane selects its own source. The sources are a fixed training placeholder word, a PRBS generator with a choice of six polynomial lengths, a repeating 264-bit custom pattern, or a square wave with a programmable half-period.

Configuration is held on plain input ports that a register block outside this unit drives. The generator registers its lane outputs once, so each output word reflects the inputs sampled at the same clock edge. Lanes at or above the configured lane count are held at zero. Their generators keep running, so gating does not restart them. A change to the link mode, or to a lane's pattern select or PRBS select, restarts that lane's generator. The lane's next output word is then the first word of the new pattern.

Top module: `link_pattern_gen`

## Requirements
- R1: While rst_n is low at a clock edge, every lane output is zero after that edge.
- R2: With link_mode = 0 (payload), each active lane outputs the payload word it was given at the previous clock edge.
- R3: With link_mode = 1 every active lane outputs 32'h4A4A4A4A, and with link_mode = 2 every active lane outputs 32'h45454545. The per-lane selects have no effect on these outputs.
- R4: Lane i is active when i <= lane_cnt: code 0 enables lane 0, code 1 enables lanes 0 and 1, code 2 enables lanes 0 to 2, and code 3 enables all four. Inactive lanes output zero, and a change of lane_cnt does not restart any generator.
- R5: With link_mode = 3, a lane pattern select of 2 gives PRBS. The generator is a Fibonacci LFSR that shifts in s[n-1]^s[t-1] each step, and that new bit is also the output bit. Each word carries 32 steps, with the first step in bit 31. The PRBS select codes give (n,t) as 0:(7,6), 1:(9,5), 2:(11,9), 3:(15,14), 4:(23,18), and any other code (31,28). A restart seeds all n bits to one.
- R6: Pattern select 3 gives the custom pattern. Pattern byte k is custom_words[8k+7:8k], so within each 24-bit word the low byte is the earliest. A word carries four consecutive bytes, with the earliest byte in bits 31:24. The byte pointer advances by 4 modulo 33 and starts at 0 on a restart.
- R7: Pattern select 4 gives a square wave. After a restart the lane outputs all-ones words for W clocks, then all-zero words for W clocks, and then repeats. W is sq_width, and a value of 0 acts as 1.
- R8: A change in link_mode or in a lane's pattern or PRBS select, relative to the value at the previous edge, makes that lane's next word the first word of the newly selected pattern.
- R9: Each lane selects its pattern independently of the others. In test mode, pattern select 0 gives the R3 mode-1 word, 1 gives the R3 mode-2 word, and codes 5 to 7 give zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_mode | input | 2 | 0 payload, 1 training 1, 2 training 2, 3 test pattern |
| lane_cnt | input | 2 | Active lane count code |
| pat_sel | input | 12 | Per-lane pattern select, 3 bits per lane, lane i at [3i+2:3i] |
| prbs_sel | input | 12 | Per-lane PRBS length select, 3 bits per lane |
| custom_words | input | 264 | Custom pattern, eleven 24-bit words, word j at [24j+23:24j] |
| sq_width | input | 8 | Square wave half-period in symbols |
| payload | input | 128 | Payload words, lane i at [32i+31:32i] |
| lane_data | output | 128 | Lane output words, lane i at [32i+31:32i] |

## Verification
Two functions can act on the same edge. One is a generator restart caused by a select change. The other is lane gating through a change of lane_cnt, which must not restart anything. The bench changes lane 0's PRBS select and lane_cnt on the same cycle while other lanes keep streaming. It also briefly deselects the custom pattern mid-stream, so the pointer restart arrives close to a wrap. A reference model that tracks restart and gating separately predicts every lane word, and each cycle's full output vector is compared against it.

// File: rtl/lpg_pkg.sv
// Shared encodings for the link pattern generator.
package lpg_pkg;
    localparam logic [1:0] MODE_PAYLOAD = 2'd0;
    localparam logic [1:0] MODE_TRAIN1  = 2'd1;
    localparam logic [1:0] MODE_TRAIN2  = 2'd2;
    localparam logic [1:0] MODE_TEST    = 2'd3;

    localparam logic [2:0] PAT_TS1    = 3'd0;
    localparam logic [2:0] PAT_TS2    = 3'd1;
    localparam logic [2:0] PAT_PRBS   = 3'd2;
    localparam logic [2:0] PAT_CUSTOM = 3'd3;
    localparam logic [2:0] PAT_SQUARE = 3'd4;

    localparam logic [7:0] TS1_BYTE = 8'h4A;
    localparam logic [7:0] TS2_BYTE = 8'h45;

    // LFSR length for a PRBS select code.
    function automatic int prbs_len(input logic [2:0] sel);
        case (sel)
            3'd0:    return 7;
            3'd1:    return 9;
            3'd2:    return 11;
            3'd3:    return 15;
            3'd4:    return 23;
            default: return 31;
        endcase
    endfunction

    // Second feedback tap for a PRBS select code.
    function automatic int prbs_tap(input logic [2:0] sel);
        case (sel)
            3'd0:    return 6;
            3'd1:    return 5;
            3'd2:    return 9;
            3'd3:    return 14;
            3'd4:    return 18;
            default: return 28;
        endcase
    endfunction
endpackage

// File: rtl/lpg_prbs.sv
// PRBS source for one lane: Fibonacci LFSR of selectable length, SYM_W steps
// per clock, first step in the MSB. Assumes ST_W >= longest polynomial.
module lpg_prbs #(
    parameter int SYM_W = 32,
    parameter int ST_W  = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [2:0]       sel,
    output logic [SYM_W-1:0] word
);
    import lpg_pkg::*;

    logic [ST_W-1:0] st_q;
    logic [ST_W-1:0] nxt;

    // Unroll SYM_W LFSR steps from the current or freshly seeded state.
    always_comb begin
        int n;
        int t;
        logic [ST_W-1:0] mask;
        logic [ST_W-1:0] s;
        logic fb;
        n    = prbs_len(sel);
        t    = prbs_tap(sel);
        mask = (ST_W'(1) << n) - ST_W'(1);
        s    = restart ? mask : st_q;
        word = '0;
        for (int i = SYM_W - 1; i >= 0; i--) begin
            fb      = s[n-1] ^ s[t-1];
            word[i] = fb;
            s       = ((s << 1) | ST_W'(fb)) & mask;
        end
        nxt = s;
    end

    // Hold the LFSR state between words.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= nxt;
    end

    // A seeded LFSR never collapses to the all-zero lock-up state.
    p_lfsr_live_r5: assert property (@(posedge clk) disable iff (!rst_n) st_q != '0);
endmodule

// File: rtl/lpg_custom.sv
// Custom pattern source for one lane: walks a PAT_BYTES-byte pattern, SYM_W/8
// bytes per clock, earliest byte in the top bits. Assumes SYM_W/8 < PAT_BYTES.
module lpg_custom #(
    parameter int SYM_W     = 32,
    parameter int PAT_BYTES = 33,
    parameter int PTR_W     = $clog2(PAT_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   restart,
    input  logic [PAT_BYTES*8-1:0] pattern,
    output logic [SYM_W-1:0]       word
);
    localparam int SYM_B = SYM_W / 8;

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] nxt;

    // Gather SYM_B bytes from the pointer with wrap, and advance it.
    always_comb begin
        int p;
        int idx;
        p    = restart ? 0 : int'(ptr_q);
        word = '0;
        for (int b = 0; b < SYM_B; b++) begin
            idx = p + b;
            if (idx >= PAT_BYTES) idx = idx - PAT_BYTES;
            word[SYM_W-1-8*b -: 8] = pattern[8*idx +: 8];
        end
        idx = p + SYM_B;
        if (idx >= PAT_BYTES) idx = idx - PAT_BYTES;
        nxt = PTR_W'(idx);
    end

    // Byte pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= nxt;
    end

    p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n) int'(ptr_q) < PAT_BYTES);
endmodule

// File: rtl/lpg_square.sv
// Square wave source for one lane: width words high, then width words low,
// starting high on restart. A width of zero acts as one.
module lpg_square #(
    parameter int SYM_W = 32,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] width,
    output logic [SYM_W-1:0] word
);
    logic [CNT_W-1:0] cnt_q;
    logic             phase_q;
    logic [CNT_W-1:0] cnt_d;
    logic             phase_d;

    // Emit the current half-period level and step the counter.
    always_comb begin
        logic [CNT_W:0] ec;
        logic [CNT_W:0] lim;
        logic           ep;
        ec   = restart ? '0 : {1'b0, cnt_q};
        ep   = restart ? 1'b1 : phase_q;
        lim  = (width == '0) ? (CNT_W+1)'(1) : {1'b0, width};
        word = {SYM_W{ep}};
        if (ec + 1'b1 >= lim) begin
            cnt_d   = '0;
            phase_d = ~ep;
        end else begin
            cnt_d   = CNT_W'(ec + 1'b1);
            phase_d = ep;
        end
    end

    // Counter and level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b1;
        end else begin
            cnt_q   <= cnt_d;
            phase_q <= phase_d;
        end
    end
endmodule

// File: rtl/lpg_lane.sv
// One output lane: detects configuration changes, runs the three pattern
// sources and registers the selected word, zeroed when the lane is inactive.
module lpg_lane #(
    parameter int SYM_W     = 32,
    parameter int PAT_BYTES = 33,
    parameter int SQ_W      = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   active,
    input  logic [1:0]             mode,
    input  logic [2:0]             pat_sel,
    input  logic [2:0]             prbs_sel,
    input  logic [SYM_W-1:0]       payload,
    input  logic [PAT_BYTES*8-1:0] pattern,
    input  logic [SQ_W-1:0]        sq_width,
    output logic [SYM_W-1:0]       out_q
);
    import lpg_pkg::*;

    localparam int CFG_W = 8;

    logic [CFG_W-1:0] cfg_q;
    logic [CFG_W-1:0] cfg;
    logic             restart;
    logic [SYM_W-1:0] prbs_w, cust_w, sq_w, sel_w;

    assign cfg     = {mode, pat_sel, prbs_sel};
    assign restart = (cfg != cfg_q);

    // Remember the configuration seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg;
    end

    lpg_prbs #(.SYM_W(SYM_W)) u_prbs (
        .clk(clk), .rst_n(rst_n), .restart(restart), .sel(prbs_sel), .word(prbs_w)
    );

    lpg_custom #(.SYM_W(SYM_W), .PAT_BYTES(PAT_BYTES)) u_cust (
        .clk(clk), .rst_n(rst_n), .restart(restart), .pattern(pattern), .word(cust_w)
    );

    lpg_square #(.SYM_W(SYM_W), .CNT_W(SQ_W)) u_sq (
        .clk(clk), .rst_n(rst_n), .restart(restart), .width(sq_width), .word(sq_w)
    );

    // Choose the lane word from the global mode and the lane selects.
    always_comb begin
        case (mode)
            MODE_PAYLOAD: sel_w = payload;
            MODE_TRAIN1:  sel_w = {(SYM_W/8){TS1_BYTE}};
            MODE_TRAIN2:  sel_w = {(SYM_W/8){TS2_BYTE}};
            default: begin
                case (pat_sel)
                    PAT_TS1:    sel_w = {(SYM_W/8){TS1_BYTE}};
                    PAT_TS2:    sel_w = {(SYM_W/8){TS2_BYTE}};
                    PAT_PRBS:   sel_w = prbs_w;
                    PAT_CUSTOM: sel_w = cust_w;
                    PAT_SQUARE: sel_w = sq_w;
                    default:    sel_w = '0;
                endcase
            end
        endcase
    end

    // Registered lane output with lane gating.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= '0;
        else if (active) out_q <= sel_w;
        else             out_q <= '0;
    end

    p_payload_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PAYLOAD && active) |=> out_q == $past(payload));
    p_train1_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TRAIN1 && active) |=> out_q == {(SYM_W/8){TS1_BYTE}});
    p_sq_restart_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && mode == MODE_TEST && pat_sel == PAT_SQUARE && active) |=> out_q == '1);
endmodule

// File: rtl/link_pattern_gen.sv
// Four-lane link symbol generator: payload, training or per-lane test
// patterns under a global mode, with lane-count gating. Outputs registered.
module link_pattern_gen #(
    parameter int LANES      = 4,
    parameter int SYM_W      = 32,
    parameter int CUST_WORDS = 11,
    parameter int CUST_W     = 24,
    parameter int SQ_W       = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    link_mode,
    input  logic [$clog2(LANES)-1:0]      lane_cnt,
    input  logic [LANES*3-1:0]            pat_sel,
    input  logic [LANES*3-1:0]            prbs_sel,
    input  logic [CUST_WORDS*CUST_W-1:0]  custom_words,
    input  logic [SQ_W-1:0]               sq_width,
    input  logic [LANES*SYM_W-1:0]        payload,
    output logic [LANES*SYM_W-1:0]        lane_data
);
    localparam int PAT_BITS  = CUST_WORDS * CUST_W;
    localparam int PAT_BYTES = PAT_BITS / 8;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic act;
        assign act = (int'(lane_cnt) >= i);

        lpg_lane #(.SYM_W(SYM_W), .PAT_BYTES(PAT_BYTES), .SQ_W(SQ_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .active(act), .mode(link_mode),
            .pat_sel(pat_sel[3*i +: 3]), .prbs_sel(prbs_sel[3*i +: 3]),
            .payload(payload[SYM_W*i +: SYM_W]), .pattern(custom_words),
            .sq_width(sq_width), .out_q(lane_data[SYM_W*i +: SYM_W])
        );

        p_gate_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (int'($past(lane_cnt)) < i) |-> lane_data[SYM_W*i +: SYM_W] == '0);
    end
endmodule

// File: tb/sim_link_pattern_gen.sv
module sim_link_pattern_gen;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   link_mode;
    logic [1:0]   lane_cnt;
    logic [11:0]  pat_sel;
    logic [11:0]  prbs_sel;
    logic [263:0] custom_words;
    logic [7:0]   sq_width;
    logic [127:0] payload;
    logic [127:0] lane_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct { logic [127:0] v; string tag; } item_t;
    item_t sb[$];

    // Reference model state per lane
    logic [30:0] m_lfsr [4];
    int          m_ptr  [4];
    int          m_cnt  [4];
    bit          m_ph   [4];
    logic [7:0]  m_cfg  [4];

    always #5 clk = ~clk;

    link_pattern_gen u0 (
        .clk(clk), .rst_n(rst_n), .link_mode(link_mode), .lane_cnt(lane_cnt),
        .pat_sel(pat_sel), .prbs_sel(prbs_sel), .custom_words(custom_words),
        .sq_width(sq_width), .payload(payload), .lane_data(lane_data)
    );

    function automatic logic [31:0] mdl_prbs(int l, bit rs, logic [2:0] sel);
        int n, t;
        logic [30:0] mask, s;
        logic [31:0] w;
        logic fb;
        case (sel)
            3'd0: begin n = 7;  t = 6;  end
            3'd1: begin n = 9;  t = 5;  end
            3'd2: begin n = 11; t = 9;  end
            3'd3: begin n = 15; t = 14; end
            3'd4: begin n = 23; t = 18; end
            default: begin n = 31; t = 28; end
        endcase
        mask = '0;
        for (int k = 0; k < n; k++) mask[k] = 1'b1;
        s = rs ? mask : m_lfsr[l];
        for (int j = 0; j < 32; j++) begin
            fb = s[n-1] ^ s[t-1];
            w[31-j] = fb;
            s = {s[29:0], fb} & mask;
        end
        m_lfsr[l] = s;
        return w;
    endfunction

    function automatic logic [31:0] mdl_cust(int l, bit rs);
        int p;
        logic [31:0] w;
        p = rs ? 0 : m_ptr[l];
        for (int b = 0; b < 4; b++) w[31-8*b -: 8] = custom_words[8*((p+b)%33) +: 8];
        m_ptr[l] = (p + 4) % 33;
        return w;
    endfunction

    function automatic logic [31:0] mdl_sq(int l, bit rs);
        int c, lim;
        bit ph;
        c   = rs ? 0 : m_cnt[l];
        ph  = rs ? 1'b1 : m_ph[l];
        lim = (sq_width == 0) ? 1 : int'(sq_width);
        if (c + 1 >= lim) begin m_cnt[l] = 0; m_ph[l] = ~ph; end
        else begin m_cnt[l] = c + 1; m_ph[l] = ph; end
        return ph ? 32'hFFFF_FFFF : 32'h0;
    endfunction

    task automatic model_reset();
        for (int l = 0; l < 4; l++) begin
            m_lfsr[l] = '1; m_ptr[l] = 0; m_cnt[l] = 0; m_ph[l] = 1'b1; m_cfg[l] = '0;
        end
    endtask

    // Driver: predict the word for the coming edge, push it, wait a cycle.
    task automatic cyc(string tag);
        item_t it;
        for (int l = 0; l < 4; l++) begin
            logic [7:0] cfg;
            logic [2:0] ps;
            bit rs;
            logic [31:0] wp, wc, ws, w;
            ps  = pat_sel[3*l +: 3];
            cfg = {link_mode, ps, prbs_sel[3*l +: 3]};
            rs  = (cfg != m_cfg[l]);
            m_cfg[l] = cfg;
            wp = mdl_prbs(l, rs, prbs_sel[3*l +: 3]);
            wc = mdl_cust(l, rs);
            ws = mdl_sq(l, rs);
            case (link_mode)
                2'd0: w = payload[32*l +: 32];
                2'd1: w = 32'h4A4A_4A4A;
                2'd2: w = 32'h4545_4545;
                default: case (ps)
                    3'd0: w = 32'h4A4A_4A4A;
                    3'd1: w = 32'h4545_4545;
                    3'd2: w = wp;
                    3'd3: w = wc;
                    3'd4: w = ws;
                    default: w = 32'h0;
                endcase
            endcase
            if (l > int'(lane_cnt)) w = 32'h0;
            it.v[32*l +: 32] = w;
        end
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    // Monitor: compare each registered output against the queued prediction.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            item_t e;
            e = sb.pop_front();
            n_tests++;
            if (lane_data !== e.v) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", e.tag, lane_data, e.v);
            end
        end
    end

    task automatic set_pats(logic [2:0] a, logic [2:0] b, logic [2:0] c, logic [2:0] d);
        pat_sel = {d, c, b, a};
    endtask

    task automatic set_prbs(logic [2:0] a, logic [2:0] b, logic [2:0] c, logic [2:0] d);
        prbs_sel = {d, c, b, a};
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0; link_mode = 0; lane_cnt = 3; pat_sel = 0; prbs_sel = 0;
        sq_width = 0; payload = '1;
        for (int k = 0; k < 33; k++) custom_words[8*k +: 8] = 8'(k * 29 + 7);
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset clears every lane
        n_tests++;
        if (lane_data !== '0) begin
            n_fail++;
            $display("FAIL R1: got %h expected 0", lane_data);
        end
        rst_n = 1;

        // R2: payload pass-through on all lanes
        for (int k = 0; k < 4; k++) begin
            for (int l = 0; l < 4; l++) payload[32*l +: 32] = 32'h1357_0000 + 32'(k * 16 + l);
            cyc("R2");
        end

        // R4: lane-count gating, codes 0, 1, 2
        for (int c = 0; c < 3; c++) begin
            lane_cnt = 2'(c);
            for (int k = 0; k < 2; k++) begin
                payload = {4{32'hC0DE_0000 + 32'(c * 4 + k)}};
                cyc("R4");
            end
        end
        lane_cnt = 3;

        // R3: training words regardless of lane selects
        link_mode = 1; set_pats(2, 3, 4, 6);
        repeat (3) cyc("R3");
        link_mode = 2;
        repeat (3) cyc("R3");

        // R5: PRBS of every length
        link_mode = 3; set_pats(2, 2, 2, 2); set_prbs(0, 1, 2, 3);
        repeat (20) cyc("R5");
        set_prbs(4, 5, 0, 1);
        repeat (20) cyc("R5");

        // R6: custom pattern over several wraps
        set_pats(3, 3, 3, 3);
        repeat (40) cyc("R6");

        // R7: square wave, width 3 then 0 acts as 1
        sq_width = 3; set_pats(4, 4, 4, 4);
        repeat (14) cyc("R7");
        sq_width = 0; link_mode = 0; cyc("R7");
        link_mode = 3;
        repeat (4) cyc("R7");

        // R9: independent lanes, including an unused code
        sq_width = 2; set_pats(2, 3, 4, 6); set_prbs(5, 0, 0, 0);
        repeat (12) cyc("R9");
        set_pats(0, 1, 7, 5);
        repeat (2) cyc("R9");
        set_pats(2, 3, 4, 6);
        repeat (6) cyc("R9");

        // R8: restart and gating on the same edge, custom restart mid-stream
        set_prbs(3, 0, 0, 0); lane_cnt = 1;
        repeat (6) cyc("R8");
        lane_cnt = 3; set_pats(2, 0, 4, 6);
        cyc("R8");
        set_pats(2, 3, 4, 6);
        repeat (10) cyc("R8");

        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule